// File: doc/BRIEF.md
# Nonvolatile Command Sequence Detector

This block sits beside a shadowed SRAM and watches its bus cycles. Each cycle is marked by a falling edge of the active-low chip enable. The block looks for a fixed run of six read cycles hidden among ordinary accesses. The first five addresses of that run are 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, in that order. The sixth address decides the command: 0x0F0F requests a STORE, which copies the SRAM array into its nonvolatile shadow. 0x0F0E requests a RECALL, which copies the shadow back into the SRAM.

When either command matches, the block pulses the matching start output for one cycle. It then holds `busy` for a fixed number of clock cycles. That number comes from the clock rate and the duration of the operation. While `busy` is high, the SRAM is treated as deselected: `out_disable` forces the data pins to high impedance, and chip-enable edges are dropped. When the count ends, normal access resumes.

The chip-enable, write-enable and address pins are asynchronous to the clock. They pass through a synchroniser before an edge detector samples them. The state machine has seven states:
- `ST_IDLE`: nothing matched yet.
- `ST_GOT1` to `ST_GOT5`: that many steps of the run have matched.
- `ST_BUSY`: an operation is timing out.

Its transitions are:
- **advance**: the expected read address moves the machine to the next GOT state.
- **restart**: a wrong address moves it to `ST_GOT1` if the address is 0x0000, otherwise to `ST_IDLE`.
- **abort**: any write moves it to `ST_IDLE`.
- **launch**: `ST_GOT5` moves to `ST_BUSY` on 0x0F0F or 0x0F0E.
- **finish**: the last busy cycle moves `ST_BUSY` to `ST_IDLE`.

Top module: `nv_seq_detect`

## Requirements
- R1: A read run 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F raises `store_start` for exactly one clock cycle. The pulse is visible after the third rising clock edge that follows the sixth chip-enable fall.
- R2: The same run ending in 0x0F0E raises `recall_start` for one cycle with the same latency, and `store_start` stays low.
- R3: A cycle with `we_n` low (a write) at any step throws away all progress. This holds even when the write is at 0x0000, which does not count as a first step.
- R4: A read at an address that is not the expected one throws away progress. If that address is 0x0000, it counts as the first step of a new run. A sixth address other than 0x0F0F or 0x0F0E starts no command.
- R5: The level of `oe_n` has no effect on whether a run is recognised.
- R6: `busy` rises in the same cycle as a start pulse. It stays high for exactly STORE_US×CLK_MHZ cycles after a STORE and RECALL_US×CLK_MHZ cycles after a RECALL.
- R7: Chip-enable falls while `busy` is high start no command, and progress is cleared. Steps given during busy do not count toward a run finished after busy.
- R8: `out_disable` is high whenever `busy` is high, `ce_n` is high, `oe_n` is high or `we_n` is low. Otherwise it is low.
- R9: After reset, `busy`, `store_start` and `recall_start` are low and no progress is held.
- R10: `store_start` and `recall_start` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | SRAM chip enable, active low, asynchronous |
| we_n | input | 1 | SRAM write enable, active low |
| oe_n | input | 1 | SRAM output enable, active low |
| addr | input | 13 | SRAM address |
| store_start | output | 1 | One-cycle STORE request |
| recall_start | output | 1 | One-cycle RECALL request |
| busy | output | 1 | Nonvolatile operation in progress, SRAM deselected |
| out_disable | output | 1 | Data pins must be high impedance |

## Verification
A start pulse is due after the third rising edge that follows the chip-enable fall. Two of those edges are synchroniser stages and the third is the state register. The bench therefore samples the start outputs on the third falling edge after it drives the fall. `busy` rises together with the pulse, and the bench measures its length by counting high cycles on falling edges. `out_disable` is combinational from the pins and `busy`, so it is sampled on the falling edge right after the pins change.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
    localparam int ADDR_W = 13;
    localparam int RUN_LEN = 6;

    typedef enum logic [2:0] {
        ST_IDLE, ST_GOT1, ST_GOT2, ST_GOT3, ST_GOT4, ST_GOT5, ST_BUSY
    } seq_state_t;

    localparam logic [ADDR_W-1:0] CMD_STORE  = 13'h0F0F;
    localparam logic [ADDR_W-1:0] CMD_RECALL = 13'h0F0E;

    // Expected address of each of the first five steps.
    function automatic logic [ADDR_W-1:0] step_addr(input int idx);
        logic [ADDR_W-1:0] a;
        unique case (idx)
            0:       a = 13'h0000;
            1:       a = 13'h1555;
            2:       a = 13'h0AAA;
            3:       a = 13'h1FFF;
            default: a = 13'h10F0;
        endcase
        return a;
    endfunction
endpackage

// File: rtl/ce_edge_sync.sv
module ce_edge_sync #(
    parameter int AW     = 13,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    output logic          fall,
    output logic          smp_we_n,
    output logic [AW-1:0] smp_addr
);
    localparam int PW = AW + 2;

    logic [PW-1:0] pipe [STAGES];
    logic          prev_ce;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= {2'b11, {AW{1'b0}}};
            prev_ce <= 1'b1;
        end else begin
            pipe[0] <= {ce_n, we_n, addr};
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            prev_ce <= pipe[STAGES-1][PW-1];
        end
    end

    assign fall     = prev_ce & ~pipe[STAGES-1][PW-1];
    assign smp_we_n = pipe[STAGES-1][AW];
    assign smp_addr = pipe[STAGES-1][AW-1:0];
endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
    parameter int STORE_CYC  = 100,
    parameter int RECALL_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_store,
    input  logic load_recall,
    output logic busy,
    output logic last
);
    localparam int MAXC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
    localparam int TW   = $clog2(MAXC + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (load_store)  cnt <= TW'(STORE_CYC);
        else if (load_recall) cnt <= TW'(RECALL_CYC);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign last = (cnt == TW'(1));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import nvseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall,
    input  logic              smp_we_n,
    input  logic [ADDR_W-1:0] smp_addr,
    input  logic              tmr_last,
    output logic              go_store,
    output logic              go_recall,
    output logic              store_start,
    output logic              recall_start
);
    seq_state_t st, nxt;
    logic [ADDR_W-1:0] exp_addr;
    seq_state_t        adv;

    always_comb begin
        exp_addr = step_addr(0);
        adv      = ST_GOT1;
        unique case (st)
            ST_IDLE: begin exp_addr = step_addr(0); adv = ST_GOT1; end
            ST_GOT1: begin exp_addr = step_addr(1); adv = ST_GOT2; end
            ST_GOT2: begin exp_addr = step_addr(2); adv = ST_GOT3; end
            ST_GOT3: begin exp_addr = step_addr(3); adv = ST_GOT4; end
            ST_GOT4: begin exp_addr = step_addr(4); adv = ST_GOT5; end
            ST_GOT5: begin exp_addr = CMD_STORE;    adv = ST_BUSY; end
            ST_BUSY: begin exp_addr = CMD_STORE;    adv = ST_BUSY; end
        endcase
    end

    always_comb begin
        nxt       = st;
        go_store  = 1'b0;
        go_recall = 1'b0;
        if (st == ST_BUSY) begin
            if (tmr_last) nxt = ST_IDLE;              // finish
        end else if (fall) begin
            if (!smp_we_n) begin
                nxt = ST_IDLE;                        // abort
            end else if (st == ST_GOT5 && smp_addr == CMD_STORE) begin
                nxt = ST_BUSY; go_store = 1'b1;       // launch
            end else if (st == ST_GOT5 && smp_addr == CMD_RECALL) begin
                nxt = ST_BUSY; go_recall = 1'b1;      // launch
            end else if (st != ST_GOT5 && smp_addr == exp_addr) begin
                nxt = adv;                            // advance
            end else begin
                nxt = (smp_addr == step_addr(0)) ? ST_GOT1 : ST_IDLE; // restart
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_start  <= 1'b0;
            recall_start <= 1'b0;
        end else begin
            store_start  <= go_store;
            recall_start <= go_recall;
        end
    end
endmodule

// File: rtl/nv_seq_detect.sv
module nv_seq_detect #(
    parameter int CLK_MHZ   = 50,
    parameter int STORE_US  = 10000,
    parameter int RECALL_US = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_n,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic [12:0] addr,
    output logic        store_start,
    output logic        recall_start,
    output logic        busy,
    output logic        out_disable
);
    localparam int STORE_CYC  = STORE_US * CLK_MHZ;
    localparam int RECALL_CYC = RECALL_US * CLK_MHZ;
    localparam int BUSY_MAX   = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;

    logic        fall, smp_we_n, go_store, go_recall, tmr_last;
    logic [12:0] smp_addr;

    ce_edge_sync #(.AW(13), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
        .fall(fall), .smp_we_n(smp_we_n), .smp_addr(smp_addr)
    );

    seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .fall(fall), .smp_we_n(smp_we_n),
        .smp_addr(smp_addr), .tmr_last(tmr_last),
        .go_store(go_store), .go_recall(go_recall),
        .store_start(store_start), .recall_start(recall_start)
    );

    busy_timer #(.STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load_store(go_store), .load_recall(go_recall),
        .busy(busy), .last(tmr_last)
    );

    assign out_disable = busy | ce_n | oe_n | ~we_n;
endmodule

// File: rtl/nv_seq_checker.sv
module nv_seq_checker #(
    parameter int BUSY_MAX = 100
) (
    input logic clk,
    input logic rst_n,
    input logic store_start,
    input logic recall_start,
    input logic busy,
    input logic out_disable
);
    int run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run <= 0;
        else if (busy) run <= run + 1;
        else           run <= 0;
    end

    a_r10_start_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_start && recall_start));
    a_r6_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (store_start || recall_start) |-> busy);
    a_r6_busy_rise_has_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (store_start || recall_start));
    a_r6_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run <= BUSY_MAX);
    a_r7_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !(store_start || recall_start));
    a_r8_busy_disables_out: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> out_disable);
endmodule

bind nv_seq_detect nv_seq_checker #(.BUSY_MAX(BUSY_MAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .store_start(store_start),
    .recall_start(recall_start), .busy(busy), .out_disable(out_disable)
);

// File: tb/nv_seq_detect_tb.sv
module nv_seq_detect_tb;
    localparam int CLK_MHZ = 50, STORE_US = 2, RECALL_US = 1;
    localparam int STORE_CYC = STORE_US * CLK_MHZ, RECALL_CYC = RECALL_US * CLK_MHZ;

    logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, oe_n = 1;
    logic [12:0] addr = '0;
    logic store_start, recall_start, busy, out_disable;

    int checks = 0, failures = 0;
    int n_store = 0, n_recall = 0, n_both = 0, run = 0, last_run = 0;
    bit done = 0;

    always #10 clk = ~clk;

    nv_seq_detect #(.CLK_MHZ(CLK_MHZ), .STORE_US(STORE_US), .RECALL_US(RECALL_US)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
        .store_start(store_start), .recall_start(recall_start),
        .busy(busy), .out_disable(out_disable));

    always @(negedge clk) begin
        if (store_start) n_store++;
        if (recall_start) n_recall++;
        if (store_start && recall_start) n_both++;
        if (busy) run++;
        else if (run != 0) begin last_run = run; run = 0; end
    end

    function automatic logic [12:0] seq_at(int i);
        case (i)
            0: return 13'h0000; 1: return 13'h1555; 2: return 13'h0AAA;
            3: return 13'h1FFF; default: return 13'h10F0;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(logic [12:0] a, logic w, logic o);
        @(negedge clk);
        addr = a; we_n = w; oe_n = o; ce_n = 0;
        repeat (3) @(negedge clk);
        ce_n = 1; we_n = 1;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_seq(logic [12:0] fin, logic o);
        for (int i = 0; i < 5; i++) step(seq_at(i), 1'b1, o);
        step(fin, 1'b1, o);
    endtask

    task automatic wait_idle();
        repeat (4) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Reference matcher for random stimulus: returns 1 store, 2 recall, 0 none.
    function automatic int ref_step(ref int idx, input logic [12:0] a, input logic w);
        if (!w) begin idx = 0; return 0; end
        if (idx == 5 && a == 13'h0F0F) begin idx = 0; return 1; end
        if (idx == 5 && a == 13'h0F0E) begin idx = 0; return 2; end
        if (idx < 5 && a == seq_at(idx)) begin idx++; return 0; end
        idx = (a == 13'h0000) ? 1 : 0;
        return 0;
    endfunction

    initial begin
        repeat (200000) @(negedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int s0, r0, idx, res, es, er;
        logic [12:0] a;
        logic w;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state
        chk("R9 busy", busy, 0);
        chk("R9 store_start", store_start, 0);
        chk("R9 recall_start", recall_start, 0);
        chk("R8 idle ce high", out_disable, 1);

        // R1 latency and pulse width
        for (int i = 0; i < 5; i++) step(seq_at(i), 1'b1, 1'b0);
        @(negedge clk); addr = 13'h0F0F; ce_n = 0;
        @(negedge clk); chk("R1 edge1", store_start, 0);
        @(negedge clk); chk("R1 edge2", store_start, 0);
        @(negedge clk); chk("R1 edge3", store_start, 1);
        chk("R6 busy with start", busy, 1);
        ce_n = 1;
        @(negedge clk); chk("R1 one cycle", store_start, 0);
        wait_idle();
        chk("R6 store length", last_run, STORE_CYC);
        chk("R2 no recall on store", n_recall, 0);

        // R2 recall
        s0 = n_store; r0 = n_recall;
        run_seq(13'h0F0E, 1'b0); wait_idle();
        chk("R2 recall pulse", n_recall - r0, 1);
        chk("R2 no store", n_store - s0, 0);
        chk("R6 recall length", last_run, RECALL_CYC);

        // R5 oe_n high throughout
        s0 = n_store;
        run_seq(13'h0F0F, 1'b1); wait_idle();
        chk("R5 oe ignored", n_store - s0, 1);

        // R3 write inside sequence
        s0 = n_store;
        step(13'h0000, 1, 0); step(13'h1555, 1, 0); step(13'h0AAA, 0, 0);
        step(13'h1FFF, 1, 0); step(13'h10F0, 1, 0); step(13'h0F0F, 1, 0);
        step(13'h0000, 0, 0);
        for (int i = 1; i < 5; i++) step(seq_at(i), 1'b1, 1'b0);
        step(13'h0F0F, 1, 0);
        wait_idle();
        chk("R3 write aborts", n_store - s0, 0);

        // R4 restart on 0x0000, wrong final
        s0 = n_store; r0 = n_recall;
        step(13'h0000, 1, 0); step(13'h1555, 1, 0);
        run_seq(13'h0F0F, 1'b0); wait_idle();
        chk("R4 restart at zero", n_store - s0, 1);
        s0 = n_store;
        run_seq(13'h1234, 1'b0); wait_idle();
        chk("R4 bad final", n_store - s0 + n_recall - r0, 0);
        s0 = n_store;
        for (int i = 0; i < 5; i++) step(seq_at(i), 1'b1, 1'b0);
        run_seq(13'h0F0F, 1'b0); wait_idle();
        chk("R4 zero as final restarts", n_store - s0, 1);

        // R7 ignored while busy, R8 during busy
        s0 = n_store;
        run_seq(13'h0F0F, 1'b0);
        chk("R7 busy after start", busy, 1);
        ce_n = 0; oe_n = 0; we_n = 1;
        @(negedge clk);
        chk("R8 busy forces disable", out_disable, 1);
        ce_n = 1; repeat (3) @(negedge clk);
        run_seq(13'h0F0F, 1'b0);
        wait_idle();
        chk("R7 full run during busy", n_store - s0, 1);
        s0 = n_store;
        run_seq(13'h0F0F, 1'b0);
        for (int i = 0; i < 3; i++) step(seq_at(i), 1'b1, 1'b0);
        wait_idle();
        step(13'h1FFF, 1, 0); step(13'h10F0, 1, 0); step(13'h0F0F, 1, 0);
        wait_idle();
        chk("R7 progress cleared", n_store - s0, 1);

        // R8 outside busy
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1;
        @(negedge clk); chk("R8 read drives", out_disable, 0);
        we_n = 0;
        @(negedge clk); chk("R8 write disables", out_disable, 1);
        ce_n = 1; we_n = 1;
        repeat (4) @(negedge clk);

        // Random mix
        idx = 0; es = n_store; er = n_recall;
        for (int k = 0; k < 300; k++) begin
            if ($urandom % 10 < 6) a = (idx == 5) ? (($urandom % 2) ? 13'h0F0F : 13'h0F0E) : seq_at(idx);
            else if ($urandom % 3 == 0) a = 13'($urandom);
            else a = seq_at($urandom % 5);
            w = ($urandom % 12 != 0);
            step(a, w, 1'($urandom));
            res = ref_step(idx, a, w);
            if (res == 1) es++;
            if (res == 2) er++;
            if (res != 0) wait_idle();
        end
        wait_idle();
        chk("R1 random stores", n_store, es);
        chk("R2 random recalls", n_recall, er);
        chk("R10 never both", n_both, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule